// File: doc/BRIEF.md
# Four-Channel Successive-Approximation Converter Controller

This block is the digital half of a four-input successive-approximation analog-to-digital converter. Software reaches it through a byte-wide register bus with four locations: a channel-enable register, a control register, and two result registers. Setting the start bit in the control register launches one conversion on the selected channel. The block then steers the analog multiplexer, presents trial codes to the converter's DAC and reads back the comparator, one decision per converter-clock period. When the search ends it writes the result registers, sets a read-only completion flag and clears the start bit.

The converter clock is the system clock divided by 8, 16, 32 or 64, chosen by a 2-bit field. A conversion always lasts 20 converter-clock periods: 2 periods of sampling, one period per resolved bit, and the rest as settling. A mode bit shortens the result to 8 bits. The enable bit of the selected channel must be set for the result to be valid. If it is clear, the conversion still runs its full length but reports zero.

The sequencer has four states. IDLE moves to SAMPLE on a launch. SAMPLE moves to TRIAL on its second converter tick. TRIAL moves to SETTLE on the tick that resolves the last bit (bit 0, or bit 2 in 8-bit mode). SETTLE returns to IDLE on the twentieth tick after launch, and that transition is the finish event.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, all four registers read 00h, `mux_sel` is 0 and `dac_code` is 0.
- R2: Register addresses are: 0 enable, 1 control, 2 result-high, 3 result-low. Control register fields: bit 7 completion (read-only), bit 6 start, bit 5 8-bit mode, bits 3:2 channel, bits 1:0 clock select, bit 4 reads 0. The writable fields read back as written.
- R3: A write to the control register with bit 6 set while idle launches a conversion. From the next cycle, start reads 1 and completion reads 0 until the conversion finishes.
- R4: The finish lands exactly 20 converter periods after the launching write edge. In that same cycle, start becomes 0, completion becomes 1 and the result registers are updated.
- R5: The converter period is 8, 16, 32 or 64 system clocks for clock select 0, 1, 2 or 3, as latched at launch.
- R6: In 10-bit mode, result-high bits 1:0 get result bits 9:8, its bits 7:2 read 0, and result-low gets result bits 7:0.
- R7: In 8-bit mode, only the top 8 DAC bits are searched, `dac_code` bits 1:0 stay 0, result-low gets the 8-bit result, and result-high keeps its old value.
- R8: If the selected channel's enable bit is clear at launch, the conversion still takes the full time, but the written result is zero.
- R9: Writes to the completion bit are ignored. Writing the control register without bit 6 never changes completion.
- R10: A start written while a conversion is running has no effect. The running conversion keeps its timing and its channel, and its result is reported.
- R11: During a conversion, `mux_sel` holds the channel latched at launch. The search keeps a trial bit when `cmp_in` is 1 (input at or above the trial code), so the result is the largest code the comparator accepts.
- R12: The enable register stores bits 3:0 and reads 0 in bits 7:4. The result registers ignore bus writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| mux_sel | output | 2 | Analog multiplexer channel select |
| dac_code | output | 10 | Trial code for the converter DAC |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above the trial code |

## Verification
A launching write takes effect at one clock edge. Start and cleared completion are visible in the next cycle. The finish, with the completion flag and both result registers, is due exactly 20×8×2^sel cycles after that edge. The bench counts negative edges from the launching write. It reads the control register one cycle before the due cycle, expecting start still 1, and again in the due cycle, expecting completion 1 and the results present. A start written in mid-conversion must not move that due cycle. The comparator is modelled combinationally from `dac_code` and `mux_sel`, so each trial decision stays inside its own converter period.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SAMPLE,
        ST_TRIAL,
        ST_SETTLE
    } seq_state_e;

    localparam logic [1:0] ADDR_EN   = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;
    localparam logic [1:0] ADDR_LO   = 2'd3;

    localparam int CTRL_DONE  = 7;
    localparam int CTRL_START = 6;
    localparam int CTRL_SHORT = 5;

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
    parameter int BASE_LOG2 = 3,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   pow_w;
    logic [CNT_W-1:0] cnt_lim;

    always_comb begin
        pow_w = '0;
        pow_w[BASE_LOG2 + 32'(sel)] = 1'b1;
        cnt_lim = CNT_W'(pow_w - 1'b1);
    end

    assign tick = run && (cnt_q == cnt_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_adc_pkg::*;
#(
    parameter int DATA_W       = 10,
    parameter int SHORT_W      = 8,
    parameter int SAMPLE_TICKS = 2,
    parameter int CONV_TICKS   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              short_mode,
    input  logic              tick,
    input  logic              cmp_in,
    output logic              finish,
    output logic [DATA_W-1:0] code,
    output logic [DATA_W-1:0] dac_code
);
    localparam int TICK_W = $clog2(CONV_TICKS);
    localparam int IDX_W  = $clog2(DATA_W);
    localparam logic [IDX_W-1:0]  MSB_IDX   = IDX_W'(DATA_W - 1);
    localparam logic [IDX_W-1:0]  SHORT_LSB = IDX_W'(DATA_W - SHORT_W);
    localparam logic [TICK_W-1:0] SAMP_LAST = TICK_W'(SAMPLE_TICKS - 1);
    localparam logic [TICK_W-1:0] CONV_LAST = TICK_W'(CONV_TICKS - 1);

    seq_state_e        state_q, state_d;
    logic [TICK_W-1:0] tick_cnt_q;
    logic [IDX_W-1:0]  bit_q;
    logic [DATA_W-1:0] code_q;
    logic [IDX_W-1:0]  lsb_idx;
    logic              samp_done;
    logic              last_trial;
    logic              conv_done;

    assign lsb_idx    = short_mode ? SHORT_LSB : '0;
    assign samp_done  = tick && (tick_cnt_q == SAMP_LAST);
    assign last_trial = tick && (bit_q == lsb_idx);
    assign conv_done  = tick && (tick_cnt_q == CONV_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch)     state_d = ST_SAMPLE;
            ST_SAMPLE: if (samp_done)  state_d = ST_TRIAL;
            ST_TRIAL:  if (last_trial) state_d = ST_SETTLE;
            ST_SETTLE: if (conv_done)  state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt_q <= '0;
            bit_q      <= MSB_IDX;
            code_q     <= '0;
        end else if (state_q == ST_IDLE) begin
            if (launch) begin
                tick_cnt_q <= '0;
                bit_q      <= MSB_IDX;
                code_q     <= '0;
            end
        end else if (tick) begin
            tick_cnt_q <= tick_cnt_q + 1'b1;
            if (state_q == ST_SAMPLE && samp_done) begin
                code_q[MSB_IDX] <= 1'b1;
            end
            if (state_q == ST_TRIAL) begin
                if (!cmp_in) code_q[bit_q] <= 1'b0;
                if (bit_q != lsb_idx) begin
                    bit_q <= bit_q - 1'b1;
                    code_q[IDX_W'(bit_q - 1'b1)] <= 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        finish   = (state_q == ST_SETTLE) && conv_done;
        code     = code_q;
        dac_code = (state_q == ST_IDLE) ? '0 : code_q;
    end

endmodule

// File: rtl/sar_regs.sv
module sar_regs
    import sar_adc_pkg::*;
#(
    parameter int DATA_W  = 10,
    parameter int SHORT_W = 8,
    parameter int CH_W    = 2,
    parameter int SEL_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              finish,
    input  logic [DATA_W-1:0] code,
    output logic              launch,
    output logic              busy,
    output logic              done,
    output logic              run_short,
    output logic [CH_W-1:0]   run_chan,
    output logic [SEL_W-1:0]  run_sel,
    output logic [7:0]        res_hi
);
    localparam int N_CH = 1 << CH_W;
    localparam int HI_W = DATA_W - 8;

    logic [N_CH-1:0]  en_q;
    logic             start_q, done_q, short_q;
    logic [CH_W-1:0]  chan_q;
    logic [SEL_W-1:0] sel_q;
    logic             run_ok;
    logic [HI_W-1:0]  hi_q;
    logic [7:0]       lo_q;
    logic             ctrl_wr;

    assign ctrl_wr = bus_we && (bus_addr == ADDR_CTRL);
    assign launch  = ctrl_wr && bus_wdata[CTRL_START] && !start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= '0;
            start_q   <= 1'b0;
            done_q    <= 1'b0;
            short_q   <= 1'b0;
            chan_q    <= '0;
            sel_q     <= '0;
            run_short <= 1'b0;
            run_chan  <= '0;
            run_sel   <= '0;
            run_ok    <= 1'b0;
            hi_q      <= '0;
            lo_q      <= '0;
        end else begin
            if (bus_we && (bus_addr == ADDR_EN)) en_q <= bus_wdata[N_CH-1:0];
            if (ctrl_wr) begin
                short_q <= bus_wdata[CTRL_SHORT];
                chan_q  <= bus_wdata[2 +: CH_W];
                sel_q   <= bus_wdata[SEL_W-1:0];
            end
            if (launch) begin
                start_q   <= 1'b1;
                done_q    <= 1'b0;
                run_short <= bus_wdata[CTRL_SHORT];
                run_chan  <= bus_wdata[2 +: CH_W];
                run_sel   <= bus_wdata[SEL_W-1:0];
                run_ok    <= en_q[bus_wdata[2 +: CH_W]];
            end
            if (finish) begin
                start_q <= 1'b0;
                done_q  <= 1'b1;
                if (run_short) begin
                    lo_q <= run_ok ? code[DATA_W-1 -: SHORT_W] : '0;
                end else begin
                    hi_q <= run_ok ? code[DATA_W-1:8] : '0;
                    lo_q <= run_ok ? code[7:0] : '0;
                end
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_EN:   bus_rdata = {{(8-N_CH){1'b0}}, en_q};
            ADDR_CTRL: bus_rdata = {done_q, start_q, short_q, 1'b0, chan_q, sel_q};
            ADDR_HI:   bus_rdata = {{(8-HI_W){1'b0}}, hi_q};
            default:   bus_rdata = lo_q;
        endcase
    end

    assign busy   = start_q;
    assign done   = done_q;
    assign res_hi = {{(8-HI_W){1'b0}}, hi_q};

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int DATA_W       = 10,
    parameter int SHORT_W      = 8,
    parameter int CH_W         = 2,
    parameter int SEL_W        = 2,
    parameter int BASE_LOG2    = 3,
    parameter int SAMPLE_TICKS = 2,
    parameter int CONV_TICKS   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [CH_W-1:0]   mux_sel,
    output logic [DATA_W-1:0] dac_code,
    input  logic              cmp_in
);
    logic              launch, busy, done, run_short, tick, finish;
    logic [SEL_W-1:0]  run_sel;
    logic [DATA_W-1:0] code;
    logic [7:0]        res_hi;

    sar_regs #(
        .DATA_W(DATA_W), .SHORT_W(SHORT_W), .CH_W(CH_W), .SEL_W(SEL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .finish(finish), .code(code),
        .launch(launch), .busy(busy), .done(done),
        .run_short(run_short), .run_chan(mux_sel), .run_sel(run_sel), .res_hi(res_hi)
    );

    sar_prescaler #(
        .BASE_LOG2(BASE_LOG2), .SEL_W(SEL_W)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .sel(run_sel), .tick(tick)
    );

    sar_seq #(
        .DATA_W(DATA_W), .SHORT_W(SHORT_W),
        .SAMPLE_TICKS(SAMPLE_TICKS), .CONV_TICKS(CONV_TICKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .short_mode(run_short),
        .tick(tick), .cmp_in(cmp_in), .finish(finish), .code(code), .dac_code(dac_code)
    );

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int DATA_W     = 10,
    parameter int SHORT_W    = 8,
    parameter int CH_W       = 2,
    parameter int SEL_W      = 2,
    parameter int BASE_LOG2  = 3,
    parameter int CONV_TICKS = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              run_short,
    input logic [SEL_W-1:0]  run_sel,
    input logic [CH_W-1:0]   mux_sel,
    input logic [DATA_W-1:0] dac_code
);
    logic [15:0] cyc_q;
    logic [15:0] due_cyc;

    assign due_cyc = 16'(CONV_TICKS) << (BASE_LOG2 + 32'(run_sel));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cyc_q <= '0;
        else if (!busy) cyc_q <= '0;
        else           cyc_q <= cyc_q + 1'b1;
    end

    a_r3_launch_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !done);

    a_r3_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r4_finish_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r5_conv_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (cyc_q == due_cyc));

    a_r7_short_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_short) |-> (dac_code[DATA_W-SHORT_W-1:0] == '0));

    a_r11_mux_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mux_sel));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
    .DATA_W(DATA_W), .SHORT_W(SHORT_W), .CH_W(CH_W), .SEL_W(SEL_W),
    .BASE_LOG2(BASE_LOG2), .CONV_TICKS(CONV_TICKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .run_short(run_short),
    .run_sel(run_sel), .mux_sel(mux_sel), .dac_code(dac_code)
);

// File: tb/tb_sar_adc_ctrl.sv
`timescale 1ns/1ps
module tb_sar_adc_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] mux_sel;
    logic [9:0] dac_code;
    logic       cmp_in;
    logic [9:0] ana [4];
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign cmp_in = (dac_code <= ana[mux_sel]);

    sar_adc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mux_sel(mux_sel),
        .dac_code(dac_code), .cmp_in(cmp_in)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // launch and check both sides of the due cycle (R3, R4, R5)
    task automatic convert(input logic [7:0] c);
        int per;
        logic [7:0] v;
        per = 20 * (8 << c[1:0]);
        wr(2'd1, c);
        rd(2'd1, v);
        chk("R3 start set, done cleared", {8'h0, v[7:6]}, 16'h1);
        chk("R11 mux_sel at launch", {14'h0, mux_sel}, {14'h0, c[3:2]});
        wait_cyc(per - 1);
        rd(2'd1, v);
        chk("R4 still busy one cycle early", {8'h0, v[7:6]}, 16'h1);
        wait_cyc(1);
        rd(2'd1, v);
        chk("R5 R4 finish exactly on time", {8'h0, v}, {8'h0, 1'b1, 1'b0, c[5], 1'b0, c[3:0]});
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1 reset register", {8'h0, v}, 16'h0);
        end
        chk("R1 reset mux_sel", {14'h0, mux_sel}, 16'h0);
        chk("R1 reset dac_code", {6'h0, dac_code}, 16'h0);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr(2'd0, 8'hFF);
        rd(2'd0, v);
        chk("R12 enable upper bits", {8'h0, v}, 16'h0F);
        wr(2'd1, 8'h2F);
        rd(2'd1, v);
        chk("R2 control readback", {8'h0, v}, 16'h2F);
        wr(2'd1, 8'h80);
        rd(2'd1, v);
        chk("R9 done not writable", {8'h0, v}, 16'h00);
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd(2'd2, v);
        chk("R12 result-high read-only", {8'h0, v}, 16'h0);
        rd(2'd3, v);
        chk("R12 result-low read-only", {8'h0, v}, 16'h0);
    endtask

    task automatic t_ten_bit;
        logic [7:0] v;
        convert(8'h44);
        rd(2'd2, v);
        chk("R6 R11 high byte ch1", {8'h0, v}, {14'h0, ana[1][9:8]});
        rd(2'd3, v);
        chk("R6 R11 low byte ch1", {8'h0, v}, {8'h0, ana[1][7:0]});
        convert(8'h43);
        rd(2'd2, v);
        chk("R6 high byte ch0 slow", {8'h0, v}, {14'h0, ana[0][9:8]});
        rd(2'd3, v);
        chk("R6 low byte ch0 slow", {8'h0, v}, {8'h0, ana[0][7:0]});
    endtask

    task automatic t_short;
        logic [7:0] v;
        convert(8'h4D);
        rd(2'd2, v);
        chk("R6 high byte ch3", {8'h0, v}, {14'h0, ana[3][9:8]});
        convert(8'h68);
        rd(2'd3, v);
        chk("R7 8-bit result", {8'h0, v}, {8'h0, ana[2][9:2]});
        rd(2'd2, v);
        chk("R7 high byte kept", {8'h0, v}, {14'h0, ana[3][9:8]});
    endtask

    task automatic t_disabled;
        logic [7:0] v;
        wr(2'd0, 8'h0B);
        convert(8'h48);
        rd(2'd2, v);
        chk("R8 disabled high zero", {8'h0, v}, 16'h0);
        rd(2'd3, v);
        chk("R8 disabled low zero", {8'h0, v}, 16'h0);
        wr(2'd1, 8'h04);
        rd(2'd1, v);
        chk("R9 done kept on plain write", {8'h0, v}, 16'h84);
        wr(2'd0, 8'h0F);
    endtask

    task automatic t_busy_start;
        logic [7:0] v;
        wr(2'd1, 8'h40);
        wait_cyc(40);
        wr(2'd1, 8'h4C);
        chk("R11 mux held after busy write", {14'h0, mux_sel}, 16'h0);
        wait_cyc(160 - 42 - 1);
        rd(2'd1, v);
        chk("R10 timing not restarted", {8'h0, v[7:6]}, 16'h1);
        wait_cyc(1);
        rd(2'd1, v);
        chk("R10 finish at first launch", {8'h0, v}, 16'h8C);
        rd(2'd3, v);
        chk("R10 result from first channel", {8'h0, v}, {8'h0, ana[0][7:0]});
        rd(2'd2, v);
        chk("R10 high from first channel", {8'h0, v}, {14'h0, ana[0][9:8]});
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        ana[0] = 10'h2A5;
        ana[1] = 10'h3FF;
        ana[2] = 10'h155;
        ana[3] = 10'h2C1;
        wait_cyc(3);
        t_reset();
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_regs();
        wr(2'd0, 8'h0F);
        t_ten_bit();
        t_short();
        t_disabled();
        t_busy_start();
        finish_run();
    end

endmodule